// File: doc/BRIEF.md
# Two-Port Token Latch Bank

This block holds a small set of token latches that two agents, a left port and a right port, use to claim shared resources. Each port has its own select for the bank, kept apart from any memory enable. A write through that select asks for a token or gives it back. A read through it, with output enable also asserted, tells the port whether it currently holds the token. A latch has at most one holder at a time, and holding it means the matching resource is in use.

The bank keeps a request flag per port per latch and an owner flag per port per latch. Writing 0 on data bit 0 raises the port's request for the addressed latch. Writing 1 drops that request. A request that finds the latch held by the other port is not lost. It waits, and the token moves to the waiting port on the same clock edge that the holder's release is registered. When both ports claim a free latch in the same cycle, the left port wins.

The state changes on the rising clock edge. The read path is combinational from the registered owner flags. As a result, a read issued in the cycle after a write already reflects that write.

Top module: `sema_bank`

## Requirements
- R1: After reset every latch is free and no request is pending. A read of any latch from either port returns all ones.
- R2: When a port writes (select=1, write=1) with data bit 0 equal to 0 to a latch that nobody holds, that port holds the latch from the next cycle. Its read of that latch returns all zeros.
- R3: The two ports never hold the same latch at the same time.
- R4: A request to a latch held by the other port is denied. The requester's read returns all ones, and the holder keeps the token for as long as its own request stands.
- R5: When a holder writes 1 on data bit 0 to release a latch and the other port has a pending request for it, the waiting port holds the latch from the next cycle.
- R6: When both ports request the same free latch in the same cycle, the left port gets it and the right port's request stays pending.
- R7: Only address bits 2:0 choose the latch. Values in the higher address bits change nothing.
- R8: Only data bit 0 of a write has meaning. A read needs select=1, output enable=1 and write=0, and it drives every data bit with the same value. In any other case the read data is all ones.
- R9: A write to one latch leaves the other seven latches unchanged.
- R10: A port that writes 1 while only waiting withdraws its request. A release by a port that neither holds nor waits has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_sem_sel | input | 1 | Left port bank select |
| lt_wr | input | 1 | Left port write strobe (1 = write) |
| lt_oe | input | 1 | Left port output enable |
| lt_addr | input | 16 | Left port address; bits 2:0 pick the latch |
| lt_wdata | input | 16 | Left port write data; bit 0: 0 = request, 1 = release |
| lt_rdata | output | 16 | Left port read data; all zeros = held by left |
| rt_sem_sel | input | 1 | Right port bank select |
| rt_wr | input | 1 | Right port write strobe |
| rt_oe | input | 1 | Right port output enable |
| rt_addr | input | 16 | Right port address |
| rt_wdata | input | 16 | Right port write data |
| rt_rdata | output | 16 | Right port read data; all zeros = held by right |

## Verification
Directed patterns first sweep every latch with requests whose upper address bits and upper data bits are noisy. This separates correct latch decoding and bit-0 decoding from decoding that looks at more bits. Contention patterns follow: one port holds while the other asks, a release with a waiter present, a withdrawal of a waiting request, and identical requests from both ports in one cycle. These separate queued hand-over and left priority from designs that drop or misroute a request. A pseudo-random sequence of a few hundred mixed writes from both ports closes the run, with all eight latches read back from both sides after every step. It catches any disturbance of latches that were not addressed.

// File: rtl/sema_pkg.sv
package sema_pkg;

   // default bank size and derived index width
   localparam int unsigned SEMA_COUNT_DEF = 8;

   function automatic int unsigned sema_idx_w(input int unsigned count);
      int unsigned w;
      w = 1;
      while ((1 << w) < count) w++;
      return w;
   endfunction

   // decoded write intent of one port towards one latch
   typedef struct packed {
      logic raise;
      logic drop;
   } req_op_t;

endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode
   import sema_pkg::*;
#(
   parameter int unsigned NUM_SEM = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16
) (
   input  logic              sem_sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output req_op_t           ops [NUM_SEM]
);
   localparam int unsigned IDX_W = sema_idx_w(NUM_SEM);

   logic             wr_go;
   logic [IDX_W-1:0] idx;

   assign wr_go = sem_sel && wr;
   assign idx   = addr[IDX_W-1:0];

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_lane
      logic hit;
      assign hit          = wr_go && (idx == IDX_W'(i));
      assign ops[i].raise = hit && !wdata[0];
      assign ops[i].drop  = hit &&  wdata[0];
   end

endmodule

// File: rtl/sema_cell.sv
module sema_cell
   import sema_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  req_op_t op_l,
   input  req_op_t op_r,
   output logic    own_l,
   output logic    own_r
);
   logic req_l, req_r;
   logic req_l_n, req_r_n;
   logic own_l_n, own_r_n;

   always_comb begin
      req_l_n = op_l.raise ? 1'b1 : (op_l.drop ? 1'b0 : req_l);
      req_r_n = op_r.raise ? 1'b1 : (op_r.drop ? 1'b0 : req_r);
      // left keeps or takes the token unless right holds and still asks
      own_l_n = req_l_n && (own_l || !(own_r && req_r_n));
      // right keeps, or takes it when left is not claiming it
      own_r_n = req_r_n && !own_l_n && (own_r || !req_l_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_l <= 1'b0;
         req_r <= 1'b0;
         own_l <= 1'b0;
         own_r <= 1'b0;
      end else begin
         req_l <= req_l_n;
         req_r <= req_r_n;
         own_l <= own_l_n;
         own_r <= own_r_n;
      end
   end

   assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_l && own_r));

   assert_owner_asked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l |-> req_l) and (own_r |-> req_r));

   assert_holder_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(own_r) && req_r) |-> own_r) and (($past(own_l) && req_l) |-> own_l));

   assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (($fell(own_l) && req_r) |-> own_r) and (($fell(own_r) && req_l) |-> own_l));

endmodule

// File: rtl/sema_read_view.sv
module sema_read_view
   import sema_pkg::*;
#(
   parameter int unsigned NUM_SEM = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16
) (
   input  logic               sem_sel,
   input  logic               wr,
   input  logic               oe,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_SEM-1:0] own_vec,
   output logic [DATA_W-1:0]  rdata
);
   localparam int unsigned IDX_W = sema_idx_w(NUM_SEM);

   logic held;

   always_comb begin
      held  = sem_sel && oe && !wr && own_vec[addr[IDX_W-1:0]];
      rdata = held ? '0 : '1;
   end

endmodule

// File: rtl/sema_bank.sv
module sema_bank
   import sema_pkg::*;
#(
   parameter int unsigned NUM_SEM = SEMA_COUNT_DEF,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_sem_sel,
   input  logic              lt_wr,
   input  logic              lt_oe,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic [DATA_W-1:0] lt_wdata,
   output logic [DATA_W-1:0] lt_rdata,
   input  logic              rt_sem_sel,
   input  logic              rt_wr,
   input  logic              rt_oe,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic [DATA_W-1:0] rt_wdata,
   output logic [DATA_W-1:0] rt_rdata
);
   localparam int unsigned IDX_W = sema_idx_w(NUM_SEM);

   if (NUM_SEM != (1 << IDX_W)) begin : g_bad_count
      $error("sema_bank: NUM_SEM must be a power of two");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("sema_bank: ADDR_W too narrow for the latch index");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sema_bank: DATA_W must be at least one");
   end

   req_op_t            ops_l [NUM_SEM];
   req_op_t            ops_r [NUM_SEM];
   logic [NUM_SEM-1:0] own_l;
   logic [NUM_SEM-1:0] own_r;

   sema_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .sem_sel(lt_sem_sel), .wr(lt_wr), .addr(lt_addr), .wdata(lt_wdata), .ops(ops_l)
   );
   sema_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .sem_sel(rt_sem_sel), .wr(rt_wr), .addr(rt_addr), .wdata(rt_wdata), .ops(ops_r)
   );

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
      sema_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .op_l(ops_l[i]), .op_r(ops_r[i]),
         .own_l(own_l[i]), .own_r(own_r[i])
      );
   end

   sema_read_view #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_view_l (
      .sem_sel(lt_sem_sel), .wr(lt_wr), .oe(lt_oe), .addr(lt_addr),
      .own_vec(own_l), .rdata(lt_rdata)
   );
   sema_read_view #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_view_r (
      .sem_sel(rt_sem_sel), .wr(rt_wr), .oe(rt_oe), .addr(rt_addr),
      .own_vec(own_r), .rdata(rt_rdata)
   );

   assert_uniform_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((lt_rdata == '0) || (lt_rdata == '1)) && ((rt_rdata == '0) || (rt_rdata == '1)));

   assert_idle_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(lt_sem_sel && lt_oe && !lt_wr) |-> (lt_rdata == '1)) and
      (!(rt_sem_sel && rt_oe && !rt_wr) |-> (rt_rdata == '1)));

   assert_bank_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l & own_r) == '0);

endmodule

// File: tb/sema_bank_bench.sv
module sema_bank_bench;
   localparam int PERIOD = 10;
   localparam int N  = 8;
   localparam int AW = 16;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lt_sem_sel = 0, lt_wr = 0, lt_oe = 0;
   logic rt_sem_sel = 0, rt_wr = 0, rt_oe = 0;
   logic [AW-1:0] lt_addr = '0, rt_addr = '0;
   logic [DW-1:0] lt_wdata = '0, rt_wdata = '0;
   logic [DW-1:0] lt_rdata, rt_rdata;

   int checks = 0;
   int fails  = 0;

   // 0 free, 1 left, 2 right
   int owner [N];
   bit wl [N];
   bit wr_q [N];

   always #(PERIOD/2) clk = ~clk;

   sema_bank #(.NUM_SEM(N), .ADDR_W(AW), .DATA_W(DW)) u_sema_bank (
      .clk(clk), .rst_n(rst_n),
      .lt_sem_sel(lt_sem_sel), .lt_wr(lt_wr), .lt_oe(lt_oe), .lt_addr(lt_addr),
      .lt_wdata(lt_wdata), .lt_rdata(lt_rdata),
      .rt_sem_sel(rt_sem_sel), .rt_wr(rt_wr), .rt_oe(rt_oe), .rt_addr(rt_addr),
      .rt_wdata(rt_wdata), .rt_rdata(rt_rdata)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // model: requests then owner, following R2..R6, R10
   task automatic model_step(input bit lv, input int li, input bit lb,
                             input bit rv, input int ri, input bit rb);
      if (lv) wl[li] = !lb;
      if (rv) wr_q[ri] = !rb;
      for (int k = 0; k < N; k++) begin
         if (!wl[k] && !wr_q[k]) owner[k] = 0;
         else if (owner[k] == 1 && wl[k]) owner[k] = 1;
         else if (owner[k] == 2 && wr_q[k]) owner[k] = 2;
         else if (wl[k]) owner[k] = 1;
         else owner[k] = 2;
      end
   endtask

   // one clock edge with optional writes from either port
   task automatic step(input bit lv, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input bit rv, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
      @(negedge clk);
      lt_sem_sel = lv; lt_wr = lv; lt_oe = 0; lt_addr = la; lt_wdata = ld;
      rt_sem_sel = rv; rt_wr = rv; rt_oe = 0; rt_addr = ra; rt_wdata = rd;
      @(negedge clk);
      lt_sem_sel = 0; lt_wr = 0; rt_sem_sel = 0; rt_wr = 0;
      model_step(lv, int'(la[2:0]), ld[0], rv, int'(ra[2:0]), rd[0]);
   endtask

   // read every latch from both ports; high address bits set to noise (R7)
   task automatic check_all(input string req);
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         lt_sem_sel = 1; lt_oe = 1; lt_wr = 0; lt_addr = AW'(k) | 16'hA5A0;
         rt_sem_sel = 1; rt_oe = 1; rt_wr = 0; rt_addr = AW'(k) | 16'h3C58;
         #2;
         check(req, lt_rdata, (owner[k] == 1) ? '0 : '1);
         check(req, rt_rdata, (owner[k] == 2) ? '0 : '1);
      end
      @(negedge clk);
      lt_sem_sel = 0; lt_oe = 0; rt_sem_sel = 0; rt_oe = 0;
   endtask

   initial begin
      #(PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      for (int k = 0; k < N; k++) begin owner[k] = 0; wl[k] = 0; wr_q[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;

      check_all("R1 reset state");

      // R8: read gating with the left port holding latch 1
      step(1, 16'h0001, 16'h0000, 0, '0, '0);
      @(negedge clk); lt_sem_sel = 0; lt_oe = 1; lt_addr = 16'h0001; #2;
      check("R8 no select", lt_rdata, '1);
      lt_sem_sel = 1; lt_oe = 0; #2;
      check("R8 no output enable", lt_rdata, '1);
      lt_oe = 1; #2;
      check("R8 gated read of held latch", lt_rdata, '0);
      lt_sem_sel = 0; lt_oe = 0;
      step(1, 16'h0001, 16'h0001, 0, '0, '0);

      // R2, R7, R8, R9: left claims each latch, noisy high address and data bits
      for (int k = 0; k < N; k++) begin
         step(1, AW'(k) | AW'((k * 16'h1234) & 16'hFFF8), 16'hFFFE, 0, '0, '0);
         check_all("R2 R7 R9 left claims in turn");
      end

      // R4: right asks for even latches and is refused
      for (int k = 0; k < N; k += 2) step(0, '0, '0, 1, AW'(k) | 16'h0F00, 16'h8000);
      check_all("R4 refused while held");

      // R5: left releases latch 2 with noisy data, right waiting takes it
      step(1, 16'h7FF2, 16'h5555, 0, '0, '0);
      check_all("R5 hand-over to waiter");

      // R10: right withdraws pending on latch 4, then left releases: latch free
      step(0, '0, '0, 1, 16'h0004, 16'h0001);
      step(1, 16'h0004, 16'h0001, 0, '0, '0);
      check_all("R10 withdrawn request");
      // R10: release by a port that neither holds nor waits
      step(0, '0, '0, 1, 16'h0003, 16'h0001);
      check_all("R10 stray release no effect");

      // clear everything
      for (int k = 0; k < N; k++) step(1, AW'(k), 16'h0001, 1, AW'(k), 16'h0001);
      check_all("R10 all released");

      // R6: both request free latch 5 in one cycle
      step(1, 16'h0005, 16'h0000, 1, 16'hFFFD, 16'h0000);
      check_all("R6 left wins tie");
      step(1, 16'h0005, 16'h0001, 0, '0, '0);
      check_all("R6 R5 right pending then served");
      step(0, '0, '0, 1, 16'h0005, 16'h0001);

      // R3, R9: pseudo-random mixed traffic
      lfsr = 16'hACE1;
      for (int n = 0; n < 250; n++) begin
         bit lv, rv;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         lv = lfsr[0] | lfsr[9];
         rv = lfsr[1] | lfsr[11];
         step(lv, {lfsr[15:3], lfsr[4:2]}, {lfsr[14:0], lfsr[5]},
              rv, {lfsr[12:0], lfsr[8:6]}, {lfsr[15:1], lfsr[7]});
         check_all("R3 R9 random traffic");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule